// File: doc/BRIEF.md
# Channel-Status Block Assembler with CRC

This block builds the 192-bit channel-status block that a digital audio transmitter sends one bit per frame. On every frame pulse it takes the frame position within the block and decides which bit goes out for that position. The bit comes from one of three places. For a few fixed positions it comes from active-low control pins. In professional mode, the last byte of the block carries a CRC that the block computes itself. Every other position takes its value from a serial channel-status input.

A mode input selects between professional and consumer operation. In consumer mode the control pins cover a different set of bit positions. Two of them also act as a frequency code, and when both of those pins are high a compact-disc flag is raised. Alongside the channel-status bit, the block drives a strobe that marks the first fifteen bytes of each block. The frame encoder sends the registered channel-status bit in both subframes of the frame.

Top module: `cs_block_asm`

## Requirements
- R1: While `rst_n` is low, `cs_bit` and `blk_strobe` are 0 and the CRC register holds 8'hFF.
- R2: `cs_bit` and `blk_strobe` change only on the clock edge at which `frm_go` is high. Between frame pulses they hold their value, so both subframes of a frame carry the same bit.
- R3: After a frame pulse with `frm_idx` in 0..119, `blk_strobe` is 1. After a frame pulse with `frm_idx` in 120..191, it is 0.
- R4: In professional mode (`sel_cons`=0), bit 1 = ~`pin_a`, bit 6 = ~`pin_b`, bit 7 = ~`pin_c` and bit 9 = ~`pin_d`.
- R5: In professional mode, the pin pair {`pin_e1`,`pin_e0`} sets bits 4,3,2 as follows: 11 gives 0,0,0; 10 gives 0,0,1; 01 gives 0,1,1; 00 gives 1,1,1 (values listed as bit4,bit3,bit2).
- R6: In consumer mode (`sel_cons`=1), bit 2 = ~`pin_b`, bit 3 = ~`pin_c`, bit 8 = ~`pin_e1`, bit 9 = ~`pin_e0` and bit 15 = ~`pin_d`.
- R7: In consumer mode, bit 24 = ~`pin_a` and bit 25 = ~`pin_fc1`.
- R8: `cd_flag` is high exactly when `sel_cons`, `pin_a` and `pin_fc1` are all 1. It is combinational.
- R9: Any position not covered by R4 to R7 and not inside a CRC byte takes the value of `ser_c` sampled at that frame pulse. This includes positions 184..191 in consumer mode.
- R10: In professional mode, the CRC register is preset to 8'hFF at frame 0. It then absorbs the transmitted bits of positions 0..183 in order, with each step c' = {c[6:0],0} XOR (c[7]^b ? 8'h1D : 0). Position 184+k sends c[k], for k = 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, shared with the frame encoder |
| frm_go | input | 1 | One-cycle pulse marking the start of a frame |
| frm_idx | input | 8 | Frame position within the block, 0..191 |
| ser_c | input | 1 | Serial channel-status input |
| sel_cons | input | 1 | 1 = consumer mode, 0 = professional mode |
| pin_a | input | 1 | Active-low pin for bit 1 in professional mode; frequency code bit 0 in consumer mode |
| pin_b | input | 1 | Active-low pin for bit 6 (professional) or bit 2 (consumer) |
| pin_c | input | 1 | Active-low pin for bit 7 (professional) or bit 3 (consumer) |
| pin_d | input | 1 | Active-low pin for bit 9 (professional) or bit 15 (consumer) |
| pin_e1 | input | 1 | Emphasis code high bit (professional); active-low bit 8 (consumer) |
| pin_e0 | input | 1 | Emphasis code low bit (professional); active-low bit 9 (consumer) |
| pin_fc1 | input | 1 | Frequency code bit 1 (consumer) |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| blk_strobe | output | 1 | High during the first 15 bytes of the block |
| cd_flag | output | 1 | Compact-disc mode flag |

## Verification
Two functions act in the same cycle: a dedicated-pin override, and the CRC step that must take in the overridden value rather than the serial input. At frame 0 the CRC preset also falls together with the first step. The bench drives the serial input with a pseudo-random stream and changes the pin levels every block, so overridden positions and serial positions usually disagree. The bench judges the eight CRC bits against a CRC that it computes from its own expected bit stream. A design that feeds the raw serial bit into the CRC, or that misses the preset, therefore fails at positions 184..191.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
  localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

  // one serial CRC step
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // emphasis pin pair -> {bit4,bit3,bit2}
  function automatic logic [2:0] emph_bits(input logic [1:0] em);
    case (em)
      2'b11:   return 3'b000;
      2'b10:   return 3'b001;
      2'b01:   return 3'b011;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/cs_pin_map.sv
module cs_pin_map #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             cons,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_c,
  input  logic             pin_d,
  input  logic             pin_e1,
  input  logic             pin_e0,
  input  logic             pin_fc1,
  output logic             ovr,
  output logic             ovr_val
);
  import cs_pkg::*;

  logic [2:0] emph;
  assign emph = emph_bits({pin_e1, pin_e0});

  always_comb begin
    ovr     = 1'b1;
    ovr_val = 1'b0;
    if (!cons) begin
      case (idx)
        IDX_W'(1): ovr_val = ~pin_a;
        IDX_W'(2): ovr_val = emph[0];
        IDX_W'(3): ovr_val = emph[1];
        IDX_W'(4): ovr_val = emph[2];
        IDX_W'(6): ovr_val = ~pin_b;
        IDX_W'(7): ovr_val = ~pin_c;
        IDX_W'(9): ovr_val = ~pin_d;
        default:   ovr     = 1'b0;
      endcase
    end else begin
      case (idx)
        IDX_W'(2):  ovr_val = ~pin_b;
        IDX_W'(3):  ovr_val = ~pin_c;
        IDX_W'(8):  ovr_val = ~pin_e1;
        IDX_W'(9):  ovr_val = ~pin_e0;
        IDX_W'(15): ovr_val = ~pin_d;
        IDX_W'(24): ovr_val = ~pin_a;
        IDX_W'(25): ovr_val = ~pin_fc1;
        default:    ovr     = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cs_crc.sv
module cs_crc (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic                     preset,
  input  logic                     din,
  output logic [cs_pkg::CRC_W-1:0] crc_q
);
  import cs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= CRC_INIT;
    else if (step_en) crc_q <= crc_step(preset ? CRC_INIT : crc_q, din);
  end

  // R10: the register only moves on a step
  p_crc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(crc_q));
endmodule

// File: rtl/cs_block_asm.sv
module cs_block_asm #(
  parameter int BLK_LEN    = 192,
  parameter int STROBE_END = 120,
  parameter int IDX_W      = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_go,
  input  logic [IDX_W-1:0] frm_idx,
  input  logic             ser_c,
  input  logic             sel_cons,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_c,
  input  logic             pin_d,
  input  logic             pin_e1,
  input  logic             pin_e0,
  input  logic             pin_fc1,
  output logic             cs_bit,
  output logic             blk_strobe,
  output logic             cd_flag
);
  import cs_pkg::*;

  localparam int CRC_START = BLK_LEN - CRC_W;

  logic             ovr, ovr_val;
  logic             crc_zone, crc_step_en, bit_now;
  logic [CRC_W-1:0] crc_q;
  logic [2:0]       crc_sel;

  cs_pin_map #(.IDX_W(IDX_W)) u_map (
    .idx(frm_idx), .cons(sel_cons),
    .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d),
    .pin_e1(pin_e1), .pin_e0(pin_e0), .pin_fc1(pin_fc1),
    .ovr(ovr), .ovr_val(ovr_val)
  );

  assign crc_zone    = !sel_cons && (frm_idx >= IDX_W'(CRC_START));
  assign crc_sel     = 3'(frm_idx - IDX_W'(CRC_START));
  assign bit_now     = crc_zone ? crc_q[crc_sel] : (ovr ? ovr_val : ser_c);
  assign crc_step_en = frm_go && !sel_cons && (frm_idx < IDX_W'(CRC_START));

  cs_crc u_crc (
    .clk(clk), .rst_n(rst_n), .step_en(crc_step_en),
    .preset(frm_idx == '0), .din(bit_now), .crc_q(crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_bit     <= 1'b0;
      blk_strobe <= 1'b0;
    end else if (frm_go) begin
      cs_bit     <= bit_now;
      blk_strobe <= frm_idx < IDX_W'(STROBE_END);
    end
  end

  assign cd_flag = sel_cons & pin_a & pin_fc1;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_go |=> ($stable(cs_bit) && $stable(blk_strobe)));
  p_strobe_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && frm_idx < IDX_W'(STROBE_END)) |=> blk_strobe);
  p_strobe_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && frm_idx >= IDX_W'(STROBE_END)) |=> !blk_strobe);
  p_serial_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && !ovr && !crc_zone) |=> (cs_bit == $past(ser_c)));
  p_pin_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && !sel_cons && frm_idx == IDX_W'(1)) |=> (cs_bit == !$past(pin_a)));
  p_cd_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cd_flag |-> sel_cons);
endmodule

// File: tb/sim_cs_block_asm.sv
module sim_cs_block_asm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_go = 1'b0;
  logic [7:0] frm_idx = '0;
  logic ser_c = 1'b0, sel_cons = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0, pin_d = 1'b0;
  logic pin_e1 = 1'b0, pin_e0 = 1'b0, pin_fc1 = 1'b0;
  logic cs_bit, blk_strobe, cd_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cs_block_asm u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp, input int pos);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos %0d actual %b expected %b", req, pos, act, exp);
    end
  endtask

  // CRC restated through its individual taps
  function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic b);
    logic f;
    logic [7:0] n;
    f = c[7] ^ b;
    n[0] = f;      n[1] = c[0];
    n[2] = c[1]^f; n[3] = c[2]^f; n[4] = c[3]^f;
    n[5] = c[4];   n[6] = c[5];   n[7] = c[6];
    return n;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    logic [7:0]  mcrc;
    logic        e;
    string       tag;
    repeat (3) @(negedge clk);
    chk("R1", cs_bit, 1'b0, -1);
    chk("R1", blk_strobe, 1'b0, -1);
    rst_n = 1'b1;
    for (int blk = 0; blk < 16; blk++) begin
      logic [7:0] pat;
      pat = 8'(blk * 53 + 7);
      sel_cons = blk[0];
      pin_a = pat[0]; pin_fc1 = pat[1]; pin_b = pat[2]; pin_c = pat[3];
      pin_e0 = pat[4]; pin_e1 = pat[5]; pin_d = pat[6];
      mcrc = 8'hFF;
      #1;
      chk("R8", cd_flag, sel_cons & pin_a & pin_fc1, -1);
      for (int i = 0; i < 192; i++) begin
        @(negedge clk);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        ser_c = lcg[16];
        frm_idx = 8'(i);
        frm_go = 1'b1;
        e = ser_c; tag = "R9";
        if (!sel_cons) begin
          case (i)
            1: begin e = !pin_a; tag = "R4"; end
            6: begin e = !pin_b; tag = "R4"; end
            7: begin e = !pin_c; tag = "R4"; end
            9: begin e = !pin_d; tag = "R4"; end
            2: begin e = !(pin_e1 && pin_e0); tag = "R5"; end
            3: begin e = !pin_e1; tag = "R5"; end
            4: begin e = !pin_e1 && !pin_e0; tag = "R5"; end
            default: ;
          endcase
          if (i >= 184) begin e = mcrc[i-184]; tag = "R10"; end
          else mcrc = tb_crc(i == 0 ? 8'hFF : mcrc, e);
        end else begin
          case (i)
            2:  begin e = !pin_b;   tag = "R6"; end
            3:  begin e = !pin_c;   tag = "R6"; end
            8:  begin e = !pin_e1;  tag = "R6"; end
            9:  begin e = !pin_e0;  tag = "R6"; end
            15: begin e = !pin_d;   tag = "R6"; end
            24: begin e = !pin_a;   tag = "R7"; end
            25: begin e = !pin_fc1; tag = "R7"; end
            default: ;
          endcase
        end
        @(negedge clk);
        frm_go = 1'b0;
        chk(tag, cs_bit, e, i);
        chk("R3", blk_strobe, i < 120, i);
        ser_c = ~ser_c;
        frm_idx = 8'(191 - i);
        @(negedge clk);
        chk("R2", cs_bit, e, i);
        chk("R2", blk_strobe, i < 120, i);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule